// File: doc/BRIEF.md
# Single-Cycle 32-bit RISC Core

A 32-bit processor core that fetches, decodes, executes and retires one instruction per clock cycle. It runs a small load/store instruction subset: word load and store, five register-to-register ALU operations (add, subtract, and, or, set-on-signed-less-than), branch-if-equal and an absolute jump. The core holds its own instruction and data memories as small internal arrays. A load port fills either array while the core is held in reset. After reset is released the program counter starts at address 0.

The main decoder turns the 6-bit opcode into datapath selects and a 2-bit operation class. A second decoder combines that class with the 6-bit function field to choose a 3-bit ALU operation. All instruction-dependent logic is combinational. The program counter, the register file and the data memory change only on the rising clock edge. Each retiring instruction is visible at the ports: the register write (enable, index, data), the data-memory store (enable, byte address, data) and the current program counter.

Top module: `sc_core`

## Requirements
- R1: While `rst_n` is low the program counter reads 0 and neither a register write nor a store is signalled. Both memories accept words from the load port (`ld_dmem` 0 selects instruction memory, 1 selects data memory).
- R2: Opcode 000000 writes register rd (bits 15:11) with rs op rt. Rs is in bits 25:21 and rt in bits 20:16. The function field (bits 5:0) selects the operation: 100000 add, 100010 subtract, 100100 and, 100101 or.
- R3: Function 101010 writes 1 to rd when rs is less than rt as signed 32-bit values, and 0 otherwise.
- R4: Opcode 100011 writes rt with the data word at byte address rs + sign-extended bits 15:0.
- R5: Opcode 101011 stores rt to byte address rs + sign-extended bits 15:0, and it writes no register.
- R6: Opcode 000100 sets the next PC to PC+4 + (sign-extended offset << 2) when rs equals rt, and to PC+4 otherwise. It writes no register.
- R7: Opcode 000010 sets the next PC to {PC+4 bits 31:28, bits 25:0, 00}.
- R8: Register 0 always reads as zero. A write aimed at it is dropped and shows no register write at the port.
- R9: Every instruction other than a branch or jump advances the PC by 4 in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Load-port write strobe |
| ld_dmem | input | 1 | Load target: 0 instruction memory, 1 data memory |
| ld_addr | input | LD_AW | Word index for the load port |
| ld_data | input | 32 | Word written by the load port |
| pc_o | output | 32 | Address of the instruction executing this cycle |
| rf_we_o | output | 1 | Register write committed at the next edge |
| rf_waddr_o | output | 5 | Destination register index |
| rf_wdata_o | output | 32 | Value written to the register |
| dm_we_o | output | 1 | Store committed at the next edge |
| dm_addr_o | output | 32 | Store byte address |
| dm_wdata_o | output | 32 | Store data |

## Verification
The bench keeps the default 6-bit address widths, which give 64-word instruction and data memories. That is room for a 30-instruction program with forward and backward branches, chained jumps and a data region. A 64-word data store lets the program use loads with positive and negative offsets, stores that overwrite preloaded words, and a write to register 0 that is then read back through a store. An interpreter in the bench predicts every cycle's program counter, register write and store. A monitor compares these predictions with the ports cycle by cycle.

// File: rtl/sc_core.sv
module sc_core #(
  parameter int IMEM_AW = 6,
  parameter int DMEM_AW = 6,
  parameter int LD_AW   = (IMEM_AW > DMEM_AW) ? IMEM_AW : DMEM_AW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic             ld_dmem,
  input  logic [LD_AW-1:0] ld_addr,
  input  logic [31:0]      ld_data,
  output logic [31:0]      pc_o,
  output logic             rf_we_o,
  output logic [4:0]       rf_waddr_o,
  output logic [31:0]      rf_wdata_o,
  output logic             dm_we_o,
  output logic [31:0]      dm_addr_o,
  output logic [31:0]      dm_wdata_o
);
  localparam int IMEM_WORDS = 1 << IMEM_AW;
  localparam int DMEM_WORDS = 1 << DMEM_AW;
  localparam int NREGS      = 32;

  localparam logic [5:0] OP_RTYPE = 6'b000000;
  localparam logic [5:0] OP_LOAD  = 6'b100011;
  localparam logic [5:0] OP_STORE = 6'b101011;
  localparam logic [5:0] OP_BEQ   = 6'b000100;
  localparam logic [5:0] OP_JUMP  = 6'b000010;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;

  localparam logic [1:0] CLS_MEM = 2'b00;
  localparam logic [1:0] CLS_BR  = 2'b01;
  localparam logic [1:0] CLS_REG = 2'b10;

  localparam logic [2:0] ALU_AND = 3'b000;
  localparam logic [2:0] ALU_OR  = 3'b001;
  localparam logic [2:0] ALU_ADD = 3'b010;
  localparam logic [2:0] ALU_SUB = 3'b110;
  localparam logic [2:0] ALU_SLT = 3'b111;

  logic [31:0] imem [IMEM_WORDS];
  logic [31:0] dmem [DMEM_WORDS];
  logic [31:0] rf   [NREGS];

  logic [31:0] pc_q, pc_plus4, br_target, pc_next;
  logic [31:0] instr, sext, rs_val, rt_val, alu_b, alu_y, wb_data;
  logic [5:0]  op, funct;
  logic [4:0]  rs, rt, rd, waddr;
  logic [1:0]  alu_cls;
  logic [2:0]  alu_ctl;
  logic        sel_rd, sel_imm, sel_mem, reg_write, mem_write, branch, jump, zero;
  logic        rf_we, dm_we;

  // Fetch and field split
  assign instr = imem[pc_q[IMEM_AW+1:2]];
  assign op    = instr[31:26];
  assign rs    = instr[25:21];
  assign rt    = instr[20:16];
  assign rd    = instr[15:11];
  assign funct = instr[5:0];
  assign sext  = {{16{instr[15]}}, instr[15:0]};

  // First-level decode: datapath selects and operation class
  always_comb begin
    sel_rd    = 1'b0;
    sel_imm   = 1'b0;
    sel_mem   = 1'b0;
    reg_write = 1'b0;
    mem_write = 1'b0;
    branch    = 1'b0;
    jump      = 1'b0;
    alu_cls   = CLS_MEM;
    case (op)
      OP_RTYPE: begin sel_rd = 1'b1; reg_write = 1'b1; alu_cls = CLS_REG; end
      OP_LOAD:  begin sel_imm = 1'b1; sel_mem = 1'b1; reg_write = 1'b1; end
      OP_STORE: begin sel_imm = 1'b1; mem_write = 1'b1; end
      OP_BEQ:   begin branch = 1'b1; alu_cls = CLS_BR; end
      OP_JUMP:  jump = 1'b1;
      default:  ;
    endcase
  end

  // Second-level decode: class plus function field
  always_comb begin
    case (alu_cls)
      CLS_MEM: alu_ctl = ALU_ADD;
      CLS_BR:  alu_ctl = ALU_SUB;
      CLS_REG: begin
        case (funct)
          FN_ADD:  alu_ctl = ALU_ADD;
          FN_SUB:  alu_ctl = ALU_SUB;
          FN_AND:  alu_ctl = ALU_AND;
          FN_OR:   alu_ctl = ALU_OR;
          FN_SLT:  alu_ctl = ALU_SLT;
          default: alu_ctl = ALU_ADD;
        endcase
      end
      default: alu_ctl = ALU_ADD;
    endcase
  end

  // Operands and ALU
  assign rs_val = rf[rs];
  assign rt_val = rf[rt];
  assign alu_b  = sel_imm ? sext : rt_val;

  always_comb begin
    case (alu_ctl)
      ALU_AND: alu_y = rs_val & alu_b;
      ALU_OR:  alu_y = rs_val | alu_b;
      ALU_ADD: alu_y = rs_val + alu_b;
      ALU_SUB: alu_y = rs_val - alu_b;
      ALU_SLT: alu_y = {31'd0, $signed(rs_val) < $signed(alu_b)};
      default: alu_y = '0;
    endcase
  end
  assign zero = (alu_y == 32'd0);

  // Next program counter
  assign pc_plus4  = pc_q + 32'd4;
  assign br_target = pc_plus4 + {sext[29:0], 2'b00};
  assign pc_next   = jump             ? {pc_plus4[31:28], instr[25:0], 2'b00} :
                     (branch && zero) ? br_target : pc_plus4;

  always_ff @(posedge clk) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_next;
  end

  // Write-back
  assign waddr   = sel_rd ? rd : rt;
  assign wb_data = sel_mem ? dmem[alu_y[DMEM_AW+1:2]] : alu_y;
  assign rf_we   = rst_n && reg_write && (waddr != 5'd0);
  assign dm_we   = rst_n && mem_write;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) rf[i] <= '0;
    end else if (rf_we) begin
      rf[waddr] <= wb_data;
    end
  end

  // Memories: load port and data stores
  always_ff @(posedge clk) begin
    if (ld_en && !ld_dmem) imem[ld_addr[IMEM_AW-1:0]] <= ld_data;
  end

  always_ff @(posedge clk) begin
    if (ld_en && ld_dmem)  dmem[ld_addr[DMEM_AW-1:0]] <= ld_data;
    else if (dm_we)        dmem[alu_y[DMEM_AW+1:2]]   <= rt_val;
  end

  assign pc_o       = pc_q;
  assign rf_we_o    = rf_we;
  assign rf_waddr_o = waddr;
  assign rf_wdata_o = wb_data;
  assign dm_we_o    = dm_we;
  assign dm_addr_o  = alu_y;
  assign dm_wdata_o = rt_val;

  // R9
  seq_pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!branch && !jump) |=> (pc_q == $past(pc_q) + 32'd4));

  // R7
  jump_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    jump |=> (pc_q[27:0] == {$past(instr[25:0]), 2'b00}));

  // R6
  beq_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (branch && (rs_val == rt_val)) |=> (pc_q == $past(br_target)));

  // R5
  store_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dm_we |-> !rf_we);

  // R3
  slt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_ctl == ALU_SLT) |-> (alu_y[31:1] == 31'd0));

  // R8
  zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we_o |-> (rf_waddr_o != 5'd0));
endmodule

// File: tb/sc_core_tb.sv
`timescale 1ns/1ps
module sc_core_tb;
  localparam int AW = 6;
  localparam int WORDS = 1 << AW;
  localparam int RUN_CYCLES = 45;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ld_en = 1'b0;
  logic          ld_dmem = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [31:0]   ld_data = '0;
  logic [31:0]   pc_o, rf_wdata_o, dm_addr_o, dm_wdata_o;
  logic          rf_we_o, dm_we_o;
  logic [4:0]    rf_waddr_o;

  always #2 clk = ~clk;

  sc_core #(.IMEM_AW(AW), .DMEM_AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_dmem(ld_dmem),
    .ld_addr(ld_addr), .ld_data(ld_data), .pc_o(pc_o),
    .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o),
    .dm_we_o(dm_we_o), .dm_addr_o(dm_addr_o), .dm_wdata_o(dm_wdata_o)
  );

  typedef struct {
    logic [31:0] pc;
    logic        rfwe;
    logic [4:0]  rfa;
    logic [31:0] rfd;
    logic        mwe;
    logic [31:0] ma;
    logic [31:0] md;
    string       tag;
  } item_t;

  item_t       sb[$];
  int          checks = 0;
  int          errors = 0;
  bit          go = 0;
  bit          done = 0;
  bit          reported = 0;

  logic [31:0] m_im [WORDS];
  logic [31:0] m_dm [WORDS];
  logic [31:0] m_rf [32];
  logic [31:0] m_pc;

  function automatic logic [31:0] enc_r(int s, int t, int d, logic [5:0] fn);
    return {6'b000000, 5'(s), 5'(t), 5'(d), 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] opc, int s, int t, int imm);
    return {opc, 5'(s), 5'(t), 16'(imm)};
  endfunction
  function automatic logic [31:0] enc_j(int w);
    return {6'b000010, 26'(w)};
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic build_program();
    for (int i = 0; i < WORDS; i++) begin
      m_im[i] = 32'd0;
      m_dm[i] = 32'(i * 3 + 1);
    end
    m_dm[0] = 32'd5;
    m_dm[1] = 32'hFFFF_FFF6;
    m_dm[2] = 32'h0F0F_00FF;
    m_dm[3] = 32'h00FF_0F0F;
    m_dm[5] = 32'd24;
    m_im[0]  = enc_i(6'b100011, 0, 1, 0);
    m_im[1]  = enc_i(6'b100011, 0, 2, 4);
    m_im[2]  = enc_i(6'b100011, 0, 3, 8);
    m_im[3]  = enc_i(6'b100011, 0, 4, 12);
    m_im[4]  = enc_r(1, 2, 5, 6'b100000);
    m_im[5]  = enc_r(1, 2, 6, 6'b100010);
    m_im[6]  = enc_r(3, 4, 7, 6'b100100);
    m_im[7]  = enc_r(3, 4, 8, 6'b100101);
    m_im[8]  = enc_r(2, 1, 9, 6'b101010);
    m_im[9]  = enc_r(1, 2, 10, 6'b101010);
    m_im[10] = enc_r(1, 1, 0, 6'b100000);
    m_im[11] = enc_i(6'b101011, 0, 0, 16);
    m_im[12] = enc_i(6'b100011, 0, 12, 20);
    m_im[13] = enc_i(6'b100011, 12, 11, -4);
    m_im[14] = enc_i(6'b101011, 0, 5, 28);
    m_im[15] = enc_i(6'b000100, 1, 2, 5);
    m_im[16] = enc_i(6'b000100, 1, 1, 2);
    m_im[17] = enc_r(1, 1, 13, 6'b100000);
    m_im[18] = enc_r(1, 1, 13, 6'b100000);
    m_im[19] = enc_r(2, 1, 13, 6'b100010);
    m_im[20] = enc_j(23);
    m_im[21] = enc_i(6'b101011, 0, 1, 36);
    m_im[22] = enc_j(26);
    m_im[23] = enc_i(6'b000100, 0, 0, -2);
    m_im[26] = enc_i(6'b101011, 0, 13, 32);
    m_im[27] = enc_i(6'b100011, 0, 14, 32);
    m_im[28] = enc_i(6'b101011, 0, 14, 36);
    m_im[29] = enc_j(29);
  endtask

  // Reference interpreter: one expected item per retired instruction
  task automatic drive_expected();
    item_t it;
    logic [31:0] ins, a, b, imm, nxt, addr;
    logic [5:0] opc, fn;
    for (int i = 0; i < 32; i++) m_rf[i] = 32'd0;
    m_pc = 32'd0;
    for (int c = 0; c < RUN_CYCLES; c++) begin
      ins = m_im[m_pc[AW+1:2]];
      opc = ins[31:26];
      fn  = ins[5:0];
      a   = m_rf[ins[25:21]];
      b   = m_rf[ins[20:16]];
      imm = {{16{ins[15]}}, ins[15:0]};
      nxt = m_pc + 32'd4;
      it.pc = m_pc; it.rfwe = 1'b0; it.rfa = '0; it.rfd = '0;
      it.mwe = 1'b0; it.ma = '0; it.md = '0; it.tag = "R9";
      case (opc)
        6'b000000: begin
          it.rfa = ins[15:11];
          it.tag = "R2";
          case (fn)
            6'b100010: it.rfd = a - b;
            6'b100100: it.rfd = a & b;
            6'b100101: it.rfd = a | b;
            6'b101010: begin it.rfd = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0; it.tag = "R3"; end
            default:   it.rfd = a + b;
          endcase
          it.rfwe = 1'b1;
        end
        6'b100011: begin
          addr = a + imm;
          it.rfa = ins[20:16]; it.rfd = m_dm[addr[AW+1:2]]; it.rfwe = 1'b1; it.tag = "R4";
        end
        6'b101011: begin
          addr = a + imm;
          it.mwe = 1'b1; it.ma = addr; it.md = b; it.tag = "R5";
          m_dm[addr[AW+1:2]] = b;
        end
        6'b000100: begin
          it.tag = "R6";
          if (a == b) nxt = m_pc + 32'd4 + {imm[29:0], 2'b00};
        end
        6'b000010: begin
          it.tag = "R7";
          nxt = {nxt[31:28], ins[25:0], 2'b00};
        end
        default: ;
      endcase
      if (it.rfwe && it.rfa == 5'd0) begin
        it.rfwe = 1'b0; it.tag = "R8";
      end
      if (it.rfwe) m_rf[it.rfa] = it.rfd;
      sb.push_back(it);
      m_pc = nxt;
    end
  endtask

  task automatic compare(item_t e);
    check(e.tag, "pc (R9 sequencing / R6 R7 targets)", pc_o, e.pc);
    check(e.tag, "register write enable", 32'(rf_we_o), 32'(e.rfwe));
    if (e.rfwe) begin
      check(e.tag, "register index", 32'(rf_waddr_o), 32'(e.rfa));
      check(e.tag, "register data", rf_wdata_o, e.rfd);
    end
    check(e.tag, "store enable", 32'(dm_we_o), 32'(e.mwe));
    if (e.mwe) begin
      check(e.tag, "store address", dm_addr_o, e.ma);
      check(e.tag, "store data", dm_wdata_o, e.md);
    end
  endtask

  task automatic summary();
    if (!reported) begin
      reported = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
    end
  endtask

  // Monitor: pops expected items as the design retires instructions
  initial begin
    item_t e;
    wait (go);
    #1;
    while (sb.size() > 0) begin
      e = sb.pop_front();
      compare(e);
      @(negedge clk);
      #0;
    end
    done = 1;
  end

  // Driver
  initial begin
    build_program();
    repeat (2) @(negedge clk);
    for (int i = 0; i < WORDS; i++) begin
      @(negedge clk);
      ld_en = 1'b1; ld_dmem = 1'b0; ld_addr = AW'(i); ld_data = m_im[i];
    end
    for (int i = 0; i < WORDS; i++) begin
      @(negedge clk);
      ld_en = 1'b1; ld_dmem = 1'b1; ld_addr = AW'(i); ld_data = m_dm[i];
    end
    @(negedge clk);
    ld_en = 1'b0;
    @(negedge clk);
    // R1: reset state
    check("R1", "pc in reset", pc_o, 32'd0);
    check("R1", "register write in reset", 32'(rf_we_o), 32'd0);
    check("R1", "store in reset", 32'(dm_we_o), 32'd0);
    drive_expected();
    rst_n = 1'b1;
    go = 1;
    wait (done);
    @(negedge clk);
    summary();
    $finish;
  end

  initial begin
    #40000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
    $finish;
  end
endmodule